// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

An eight-pin general-purpose I/O port behind a small byte-wide register bus. A direction register picks, pin by pin, whether the port drives the pad. An output register holds the value it drives. Pin inputs pass through a two-flop synchroniser before any logic sees them.

Data reads and writes go to a window of word-aligned addresses. Address bits [9:2] of the access form a per-pin enable. One write therefore updates any chosen subset of pins, and the other pins are not touched. One read samples that subset, and every other bit returns zero. Software never needs a read-modify-write sequence to change one pin, so it needs no lock around such a sequence.

The bus is a single-cycle valid/write/address/data request. Read data comes back registered, together with a one-cycle valid strobe.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset, the direction register, the output register, `pin_oe_o`, `pin_out_o`, `rd_data_o` and `rd_valid_o` are all zero, so every pin starts as an input.
- R2: Byte offset 0x400 holds the direction register. A write there sets it to `wr_data_i`. Bit n = 1 makes pin n an output and bit n = 0 makes it an input. `pin_oe_o` shows the new value from the clock edge that accepts the write, and a read of 0x400 returns the stored value.
- R3: A data write is a word-aligned offset in 0x000 to 0x3FC. Address bit n+2 enables pin n, so pin n alone is at offset 1 << (n+2). Output bits whose enable is clear keep their value.
- R4: A data write changes an output bit only if that pin is already an output when the write is accepted. Writing an input pin leaves its output bit unchanged, and later setting that pin to output does not bring back the value that was dropped.
- R5: A data read returns zero in every bit position whose address enable bit is clear.
- R6: In an enabled position, a data read returns the synchronised pad level if the pin is an input, and the output register bit if the pin is an output.
- R7: A change on `pin_i` first appears in a data read accepted on the third rising edge after the change. Reads accepted on the first and second edges still return the old level.
- R8: Any other offset is undefined. This includes an address with bits [1:0] not zero, an offset above 0x400, and 0x404 and beyond. A read of an undefined offset returns zero, and a write to one changes neither register.
- R9: A read accepted on a clock edge drives `rd_valid_o` high for exactly the next cycle, with its data on `rd_data_o`. A write never raises `rd_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 12 | Byte offset |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Registered read data |
| rd_valid_o | output | 1 | Read data valid strobe |
| pin_i | input | 8 | Pad input levels (asynchronous) |
| pin_out_o | output | 8 | Output register value to the pads |
| pin_oe_o | output | 8 | Per-pin output enable |

## Verification
The bench writes all pins while they are still inputs and then turns on their drivers. A design that stores the value early would drive ones instead of zeros. It uses sparse and single-pin enables to show that writes merge correctly and that reads of disabled bits come back zero; a port that ignores the enable would clobber other pins or leak their levels. Three reads in a row after a pad change pin down the synchroniser delay, which catches both a stage that is missing and a stage that was added. Misaligned addresses, addresses past the direction register and addresses outside the window must neither read back data nor change the registers, which exposes decoding that looks only at the low bits.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    ACC_DATA = 2'd0,
    ACC_DIR  = 2'd1,
    ACC_BAD  = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= async_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_decode.sv
module gpio_decode
  import gpio_pkg::*;
#(
  parameter int NPINS  = 8,
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr_i,
  output acc_kind_e         kind_o,
  output logic [NPINS-1:0]  mask_o
);
  localparam int MASK_LO = 2;
  localparam int MASK_HI = NPINS + 1;
  localparam int WIN_TOP = NPINS + 2;
  localparam logic [ADDR_W-1:0] DIR_ADDR = ADDR_W'(1) << WIN_TOP;

  assign mask_o = addr_i[MASK_HI:MASK_LO];

  always_comb begin
    if (addr_i[1:0] != 2'b00)              kind_o = ACC_BAD;
    else if (addr_i[ADDR_W-1:WIN_TOP] == '0) kind_o = ACC_DATA;
    else if (addr_i == DIR_ADDR)            kind_o = ACC_DIR;
    else                                    kind_o = ACC_BAD;
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             write_i,
  input  acc_kind_e        kind_i,
  input  logic [NPINS-1:0] mask_i,
  input  logic [NPINS-1:0] wdata_i,
  output logic [NPINS-1:0] dir_o,
  output logic [NPINS-1:0] out_o
);
  logic [NPINS-1:0] dir_q, out_q, upd;
  logic wr_dir, wr_data;

  assign wr_dir  = valid_i & write_i & (kind_i == ACC_DIR);
  assign wr_data = valid_i & write_i & (kind_i == ACC_DATA);
  // only enabled pins that already drive may change
  assign upd     = mask_i & dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '0;
      out_q <= '0;
    end else begin
      if (wr_dir)  dir_q <= wdata_i;
      if (wr_data) out_q <= (out_q & ~upd) | (wdata_i & upd);
    end
  end

  assign dir_o = dir_q;
  assign out_o = out_q;

  // R2
  dir_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && write_i && kind_i == ACC_DIR) |=> dir_o == $past(wdata_i));

  // R3 R4
  out_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && write_i && kind_i == ACC_DATA) |=>
      ((out_o ^ $past(out_o)) & ~($past(mask_i) & $past(dir_o))) == '0);

  // R8
  bad_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && write_i && kind_i == ACC_BAD) |=> ($stable(dir_o) && $stable(out_o)));
endmodule

// File: rtl/gpio_rdpath.sv
module gpio_rdpath
  import gpio_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             write_i,
  input  acc_kind_e        kind_i,
  input  logic [NPINS-1:0] mask_i,
  input  logic [NPINS-1:0] dir_i,
  input  logic [NPINS-1:0] out_i,
  input  logic [NPINS-1:0] pin_sync_i,
  output logic [NPINS-1:0] rdata_o,
  output logic             rvalid_o
);
  logic [NPINS-1:0] pin_view, rd_val;
  logic rd_req;

  assign pin_view = (dir_i & out_i) | (~dir_i & pin_sync_i);
  assign rd_req   = valid_i & ~write_i;

  always_comb begin
    unique case (kind_i)
      ACC_DATA: rd_val = mask_i & pin_view;
      ACC_DIR:  rd_val = dir_i;
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_req;
      if (rd_req) rdata_o <= rd_val;
    end
  end

  // R5
  rd_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && kind_i == ACC_DATA) |=> (rdata_o & ~$past(mask_i)) == '0);

  // R8
  bad_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && kind_i == ACC_BAD) |=> rdata_o == '0);

  // R9
  rd_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req |=> rvalid_o);

  // R9
  wr_no_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && write_i) |=> !rvalid_o);
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
  import gpio_pkg::*;
#(
  parameter int NPINS       = 8,
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [NPINS-1:0]  wr_data_i,
  output logic [NPINS-1:0]  rd_data_o,
  output logic              rd_valid_o,
  input  logic [NPINS-1:0]  pin_i,
  output logic [NPINS-1:0]  pin_out_o,
  output logic [NPINS-1:0]  pin_oe_o
);
  acc_kind_e        kind;
  logic [NPINS-1:0] mask, dir, outv, pin_sync;

  gpio_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .async_i(pin_i), .sync_o(pin_sync)
  );

  gpio_decode #(.NPINS(NPINS), .ADDR_W(ADDR_W)) i_decode (
    .addr_i(req_addr_i), .kind_o(kind), .mask_o(mask)
  );

  gpio_regs #(.NPINS(NPINS)) i_regs (
    .clk_i, .rst_ni, .valid_i(req_valid_i), .write_i(req_write_i),
    .kind_i(kind), .mask_i(mask), .wdata_i(wr_data_i),
    .dir_o(dir), .out_o(outv)
  );

  gpio_rdpath #(.NPINS(NPINS)) i_rdpath (
    .clk_i, .rst_ni, .valid_i(req_valid_i), .write_i(req_write_i),
    .kind_i(kind), .mask_i(mask), .dir_i(dir), .out_i(outv),
    .pin_sync_i(pin_sync), .rdata_o(rd_data_o), .rvalid_o(rd_valid_o)
  );

  assign pin_out_o = outv;
  assign pin_oe_o  = dir;

  // R1
  reset_idle_chk: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (pin_oe_o == '0 && pin_out_o == '0 && !rd_valid_o));
endmodule

// File: tb/test_gpio_mask_port.sv
`timescale 1ns/1ps
module test_gpio_mask_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, write = 1'b0;
  logic [11:0] addr = '0;
  logic [7:0]  wdata = '0, pin = '0;
  logic [7:0]  rdata, pout, poe;
  logic        rvalid;

  int total = 0, bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  gpio_mask_port i_gpio_mask_port (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_write_i(write),
    .req_addr_i(addr), .wr_data_i(wdata), .rd_data_o(rdata), .rd_valid_o(rvalid),
    .pin_i(pin), .pin_out_o(pout), .pin_oe_o(poe)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as strobes appear
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) chk("R9 unexpected strobe", 8'h01, 8'h00);
      else chk(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic wr(logic [11:0] a, logic [7:0] d);
    valid = 1'b1; write = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    valid = 1'b0; write = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, logic [7:0] e, string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    valid = 1'b1; write = 1'b0; addr = a;
    @(posedge clk); @(negedge clk);
    valid = 1'b0;
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 oe", poe, 8'h00);
    chk("R1 out", pout, 8'h00);
    chk("R1 rdata", rdata, 8'h00);
    chk("R1 rvalid", {7'd0, rvalid}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    rd(12'h400, 8'h00, "R1 dir read");

    // R4: write while inputs, then enable drivers
    wr(12'h3FC, 8'hFF);
    wr(12'h400, 8'h0F);
    chk("R2 oe", poe, 8'h0F);
    chk("R4 dropped write", pout, 8'h00);
    rd(12'h400, 8'h0F, "R2 dir read");

    // R3 / R4 masked writes
    wr(12'h3FC, 8'hA5);
    chk("R4 only outputs", pout, 8'h05);
    wr(12'h008, 8'hFF);                // pin1 alone
    chk("R3 single pin", pout, 8'h07);
    wr(12'h030, 8'h00);                // pins 2,3
    chk("R3 pair clear", pout, 8'h03);
    chk("R9 no strobe after write", {7'd0, rvalid}, 8'h00);

    // R7 / R6 synchroniser delay
    pin = 8'hFA;
    rd(12'h3FC, 8'h03, "R7 edge1 old");
    rd(12'h3FC, 8'h03, "R7 edge2 old");
    rd(12'h3FC, 8'hF3, "R7 edge3 new / R6 mix");

    // R5 masked reads
    rd(12'h0C0, 8'h30, "R5 mask 4,5");
    rd(12'h004, 8'h01, "R5 mask 0");
    rd(12'h000, 8'h00, "R5 empty mask");
    rd(12'h228, 8'h82, "R5 sparse mask");

    // R8 undefined offsets
    wr(12'h404, 8'hFF);
    chk("R8 wr 404 dir", poe, 8'h0F);
    wr(12'h3FE, 8'hFF);
    chk("R8 misaligned wr", pout, 8'h03);
    wr(12'h800, 8'hFF);
    chk("R8 high wr out", pout, 8'h03);
    chk("R8 high wr dir", poe, 8'h0F);
    rd(12'h404, 8'h00, "R8 rd 404");
    rd(12'h402, 8'h00, "R8 rd misaligned dir");
    rd(12'h801, 8'h00, "R8 rd high");
    rd(12'h3FD, 8'h00, "R8 rd misaligned data");

    // R6 swap directions
    wr(12'h400, 8'hF0);
    chk("R2 oe swap", poe, 8'hF0);
    rd(12'h3FC, 8'h0A, "R6 swapped view");
    chk("R3 out kept", pout, 8'h03);

    @(negedge clk);
    chk("R9 queue drained", 8'(exp_q.size()), 8'h00);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule